// File: doc/BRIEF.md
# Video DMA Cycle-Steal Scheduler

This block decides, for every machine cycle of a video line, whether the video controller takes the memory bus away from the CPU, and what the stolen cycle is used for. Each stolen cycle moves exactly one byte. A cycle can be used for a display-list byte, a player byte, a missile byte, a playfield data byte or a character code byte, or it can be a memory refresh cycle. The fixed fetches for the next line (missile, display list, players) sit at set positions inside horizontal blank. Playfield fetches come from a per-cycle request mask that an upstream timing generator supplies. The block gates that mask with the line-within-row flags and the playfield mode.

Refresh runs on a cadence of its own once horizontal blank has ended. There are nine candidate slots, four cycles apart. A slot that coincides with any DMA fetch is lost and is not moved later, so a busy line gets fewer than nine refreshes. Refresh does not depend on any enable, so it keeps running during vertical blank when all fetches are off.

The caller presents the horizontal cycle count and the line state each cycle. One clock later the block returns a registered owner code and a CPU halt line. Address generation and pixel shifting are done elsewhere.

Top module: `dma_steal_sched`

## Requirements
- R1: After a synchronous active-low reset, `owner` is 0 and `cpu_halt` is low. Owner codes are: 0 = CPU, 1 = display list, 2 = player, 3 = missile, 4 = playfield data, 5 = character code, 6 = refresh. `cpu_halt` is high exactly when `owner` is nonzero.
- R2: With `dlist_en` high and `dlist_bytes` = N (0 to 3), cycles 1 to N steal with code 1. With `dlist_en` low, those cycles do not steal.
- R3: If `missile_en` or `player_en` is high, cycle 0 steals with code 3. In one-line resolution (`pm_single` = 1) this happens on every line. In two-line resolution it happens only when `line_odd` = 0.
- R4: If `player_en` is high, cycles 4 to 7 steal with code 2. The line-parity rule of R3 applies. Enabling only missiles produces no player cycles.
- R5: In map mode (`pf_mode` = 1), a set bit of `pf_data_mask` at the current cycle steals with code 4, but only when `first_instr_line` = 1. In character mode (`pf_mode` = 2), the data mask applies on every line. With `pf_mode` = 0, both masks are ignored.
- R6: A set bit of `pf_code_mask` steals with code 5 only in character mode and only when `first_row_line` = 1.
- R7: Refresh (code 6) occurs at cycles 40, 44, …, 72, nine slots in all, when nothing else is requested there. It occurs regardless of all enable inputs.
- R8: A fetch request in a refresh slot takes that cycle, and the refresh is dropped. The following slots stay at their fixed positions.
- R9: Priority, highest first, is: missile, display list, player, character code, playfield data, refresh. A cycle count of 114 or more never steals.
- R10: `owner` and `cpu_halt` reflect the inputs present at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Machine-cycle clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hcount | input | 7 | Horizontal machine-cycle index within the line |
| line_odd | input | 1 | Parity of the current line for two-line resolution |
| first_instr_line | input | 1 | First line of the current display-list instruction |
| first_row_line | input | 1 | First line of the current character row |
| dlist_en | input | 1 | Display-list fetch enable |
| dlist_bytes | input | 2 | Number of display-list bytes to fetch for the next line (0–3) |
| player_en | input | 1 | Player DMA enable (also forces missile DMA) |
| missile_en | input | 1 | Missile DMA enable |
| pm_single | input | 1 | 1 = one-line player/missile resolution, 0 = two-line |
| pf_mode | input | 2 | Playfield mode: 0 off, 1 map, 2 character |
| pf_data_mask | input | 114 | Per-cycle playfield data fetch request |
| pf_code_mask | input | 114 | Per-cycle character code fetch request |
| owner | output | 3 | Registered bus owner code for the cycle |
| cpu_halt | output | 1 | Registered CPU halt, high while the video side owns the bus |

## Verification
A quiet line with every fetch disabled gives the baseline of exactly nine refreshes at their fixed slots. A playfield request placed on one slot then shows that the slot is dropped and that later slots are not shifted. The player/missile parity is tried with both resolutions on odd and even lines. This tells a two-line fetch apart from an every-line fetch, and missile-only DMA apart from player DMA. The map and character modes are given the same masks with the first-line flags toggled. This separates fetches done only on the first line from fetches done on every line. Masks that overlap the fixed slots show the priority order.

// File: rtl/dma_sched_pkg.sv
// Shared owner codes and playfield modes for the cycle-steal scheduler.
package dma_sched_pkg;
    typedef enum logic [2:0] {
        OWN_CPU     = 3'd0,
        OWN_DLIST   = 3'd1,
        OWN_PLAYER  = 3'd2,
        OWN_MISSILE = 3'd3,
        OWN_PFDATA  = 3'd4,
        OWN_CHCODE  = 3'd5,
        OWN_REFRESH = 3'd6
    } owner_t;

    typedef enum logic [1:0] {
        PF_OFF  = 2'd0,
        PF_MAP  = 2'd1,
        PF_CHAR = 2'd2
    } pfmode_t;
endpackage

// File: rtl/hblank_slot_decode.sv
// Decodes the fixed horizontal-blank fetch slots: missile, display list, players.
// Assumes the slot parameters do not overlap and lie before the refresh window.
module hblank_slot_decode #(
    parameter int HC_W         = 7,
    parameter int MISSILE_SLOT = 0,
    parameter int DL_SLOT      = 1,
    parameter int DL_MAX       = 3,
    parameter int PLAYER_SLOT  = 4,
    parameter int PLAYER_BYTES = 4,
    localparam int DLB_W       = $clog2(DL_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [HC_W-1:0]  hcount,
    input  logic             line_odd,
    input  logic             dlist_en,
    input  logic [DLB_W-1:0] dlist_bytes,
    input  logic             player_en,
    input  logic             missile_en,
    input  logic             pm_single,
    output logic             want_dlist,
    output logic             want_player,
    output logic             want_missile
);
    int  hc;
    logic pm_line;

    // Slot decode: position within the line, enable and line parity.
    always_comb begin
        hc           = int'(hcount);
        pm_line      = pm_single | ~line_odd;
        want_missile = (missile_en | player_en) & pm_line & (hc == MISSILE_SLOT);
        want_player  = player_en & pm_line & (hc >= PLAYER_SLOT) &
                       (hc < PLAYER_SLOT + PLAYER_BYTES);
        want_dlist   = dlist_en & (hc >= DL_SLOT) & (hc < DL_SLOT + int'(dlist_bytes));
    end

    assert_dl_within_max_R2: assert property (@(posedge clk) disable iff (!rst_n)
        want_dlist |-> (int'(hcount) < DL_SLOT + DL_MAX));

    assert_player_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        want_player |-> player_en);
endmodule

// File: rtl/pf_fetch_gate.sv
// Gates the per-cycle playfield request masks by mode and line-in-row flags.
// Assumes the masks are indexed by the horizontal cycle count.
module pf_fetch_gate #(
    parameter int LINE_CYCLES = 114,
    parameter int HC_W        = 7
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [HC_W-1:0]        hcount,
    input  logic [1:0]             pf_mode,
    input  logic                   first_instr_line,
    input  logic                   first_row_line,
    input  logic [LINE_CYCLES-1:0] pf_data_mask,
    input  logic [LINE_CYCLES-1:0] pf_code_mask,
    output logic                   want_data,
    output logic                   want_code
);
    import dma_sched_pkg::*;

    logic in_line, data_bit, code_bit;

    // Mask lookup, guarded against counts past the end of the line.
    always_comb begin
        in_line  = int'(hcount) < LINE_CYCLES;
        data_bit = in_line ? pf_data_mask[hcount] : 1'b0;
        code_bit = in_line ? pf_code_mask[hcount] : 1'b0;
    end

    // Mode gating: map data on first instruction line, char data on every line.
    always_comb begin
        unique case (pf_mode)
            PF_MAP:  begin want_data = data_bit & first_instr_line; want_code = 1'b0; end
            PF_CHAR: begin want_data = data_bit; want_code = code_bit & first_row_line; end
            default: begin want_data = 1'b0; want_code = 1'b0; end
        endcase
    end

    assert_code_only_first_row_R6: assert property (@(posedge clk) disable iff (!rst_n)
        want_code |-> (first_row_line && pf_mode == PF_CHAR));
endmodule

// File: rtl/refresh_slotter.sv
// Marks refresh slots: a fixed number of slots at a fixed stride after hblank.
// Assumes the caller drops a slot when any fetch claims the same cycle.
module refresh_slotter #(
    parameter int HC_W          = 7,
    parameter int REFRESH_START = 40,
    parameter int REFRESH_STEP  = 4,
    parameter int REFRESH_SLOTS = 9
) (
    input  logic [HC_W-1:0] hcount,
    output logic            refresh_slot
);
    logic [REFRESH_SLOTS-1:0] hit;

    for (genvar k = 0; k < REFRESH_SLOTS; k++) begin : g_slot
        // One comparator per refresh slot position.
        always_comb hit[k] = (int'(hcount) == REFRESH_START + k * REFRESH_STEP);
    end

    // Any slot position matching the current cycle.
    always_comb refresh_slot = |hit;
endmodule

// File: rtl/dma_steal_sched.sv
// Top of the cycle-steal scheduler: arbitrates fetch requests and refresh per
// machine cycle and registers the owner code and CPU halt.
// Assumes hcount advances once per clock and dlist_bytes never exceeds DL_MAX.
module dma_steal_sched #(
    parameter int LINE_CYCLES   = 114,
    parameter int DL_MAX        = 3,
    parameter int PLAYER_BYTES  = 4,
    parameter int REFRESH_START = 40,
    parameter int REFRESH_STEP  = 4,
    parameter int REFRESH_SLOTS = 9,
    localparam int HC_W         = $clog2(LINE_CYCLES),
    localparam int DLB_W        = $clog2(DL_MAX + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [HC_W-1:0]        hcount,
    input  logic                   line_odd,
    input  logic                   first_instr_line,
    input  logic                   first_row_line,
    input  logic                   dlist_en,
    input  logic [DLB_W-1:0]       dlist_bytes,
    input  logic                   player_en,
    input  logic                   missile_en,
    input  logic                   pm_single,
    input  logic [1:0]             pf_mode,
    input  logic [LINE_CYCLES-1:0] pf_data_mask,
    input  logic [LINE_CYCLES-1:0] pf_code_mask,
    output logic [2:0]             owner,
    output logic                   cpu_halt
);
    import dma_sched_pkg::*;

    localparam int MISSILE_SLOT = 0;
    localparam int DL_SLOT      = MISSILE_SLOT + 1;
    localparam int PLAYER_SLOT  = DL_SLOT + DL_MAX;

    logic   want_dlist, want_player, want_missile;
    logic   want_data, want_code, refresh_slot, any_fetch;
    owner_t next_owner;

    hblank_slot_decode #(
        .HC_W(HC_W), .MISSILE_SLOT(MISSILE_SLOT), .DL_SLOT(DL_SLOT),
        .DL_MAX(DL_MAX), .PLAYER_SLOT(PLAYER_SLOT), .PLAYER_BYTES(PLAYER_BYTES)
    ) u_slots (
        .clk(clk), .rst_n(rst_n), .hcount(hcount), .line_odd(line_odd),
        .dlist_en(dlist_en), .dlist_bytes(dlist_bytes), .player_en(player_en),
        .missile_en(missile_en), .pm_single(pm_single),
        .want_dlist(want_dlist), .want_player(want_player), .want_missile(want_missile)
    );

    pf_fetch_gate #(.LINE_CYCLES(LINE_CYCLES), .HC_W(HC_W)) u_pf (
        .clk(clk), .rst_n(rst_n), .hcount(hcount), .pf_mode(pf_mode),
        .first_instr_line(first_instr_line), .first_row_line(first_row_line),
        .pf_data_mask(pf_data_mask), .pf_code_mask(pf_code_mask),
        .want_data(want_data), .want_code(want_code)
    );

    refresh_slotter #(
        .HC_W(HC_W), .REFRESH_START(REFRESH_START),
        .REFRESH_STEP(REFRESH_STEP), .REFRESH_SLOTS(REFRESH_SLOTS)
    ) u_refresh (
        .hcount(hcount), .refresh_slot(refresh_slot)
    );

    // Fixed-priority arbitration; refresh only takes a cycle no fetch wants.
    always_comb begin
        any_fetch = want_missile | want_dlist | want_player | want_code | want_data;
        if (want_missile)      next_owner = OWN_MISSILE;
        else if (want_dlist)   next_owner = OWN_DLIST;
        else if (want_player)  next_owner = OWN_PLAYER;
        else if (want_code)    next_owner = OWN_CHCODE;
        else if (want_data)    next_owner = OWN_PFDATA;
        else if (refresh_slot) next_owner = OWN_REFRESH;
        else                   next_owner = OWN_CPU;
    end

    // Output register for the owner code and the CPU halt line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner    <= OWN_CPU;
            cpu_halt <= 1'b0;
        end else begin
            owner    <= next_owner;
            cpu_halt <= any_fetch | refresh_slot;
        end
    end

    assert_halt_tracks_owner_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_halt == (owner != OWN_CPU));

    assert_refresh_in_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (next_owner == OWN_REFRESH) |->
        (int'(hcount) >= REFRESH_START &&
         int'(hcount) < REFRESH_START + REFRESH_SLOTS * REFRESH_STEP &&
         (int'(hcount) - REFRESH_START) % REFRESH_STEP == 0));

    assert_preempt_drops_refresh_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_slot && any_fetch) |=> (owner != OWN_REFRESH && cpu_halt));

    assert_missile_parity_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (next_owner == OWN_MISSILE) |-> (pm_single || !line_odd));

    assert_no_steal_past_line_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(hcount) >= LINE_CYCLES) |=> !cpu_halt);
endmodule

// File: tb/dma_steal_sched_test.sv
// Directed bench for the cycle-steal scheduler, one task per scenario.
module dma_steal_sched_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [6:0]   hcount = '0;
    logic         line_odd = 1'b0, first_instr_line = 1'b0, first_row_line = 1'b0;
    logic         dlist_en = 1'b0, player_en = 1'b0, missile_en = 1'b0, pm_single = 1'b1;
    logic [1:0]   dlist_bytes = '0;
    logic [1:0]   pf_mode = '0;
    logic [113:0] pf_data_mask = '0, pf_code_mask = '0;
    logic [2:0]   owner;
    logic         cpu_halt;
    int checks = 0, fails = 0;

    always #2.5 clk = ~clk;

    dma_steal_sched uut (
        .clk(clk), .rst_n(rst_n), .hcount(hcount), .line_odd(line_odd),
        .first_instr_line(first_instr_line), .first_row_line(first_row_line),
        .dlist_en(dlist_en), .dlist_bytes(dlist_bytes), .player_en(player_en),
        .missile_en(missile_en), .pm_single(pm_single), .pf_mode(pf_mode),
        .pf_data_mask(pf_data_mask), .pf_code_mask(pf_code_mask),
        .owner(owner), .cpu_halt(cpu_halt)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Present one cycle count, then sample the registered result after the edge.
    task automatic step(int hc);
        @(negedge clk);
        hcount = 7'(hc);
        @(posedge clk);
        #1;
    endtask

    task automatic check_cycle(string req, int hc, int exp);
        step(hc);
        check(req, int'(owner), exp);
        check({req, " halt"}, int'(cpu_halt), exp != 0);
    endtask

    task automatic clear_all();
        dlist_en = 0; player_en = 0; missile_en = 0; pm_single = 1; line_odd = 0;
        first_instr_line = 0; first_row_line = 0; pf_mode = 0;
        pf_data_mask = '0; pf_code_mask = '0; dlist_bytes = 0;
    endtask

    task automatic t_reset();
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset owner", int'(owner), 0);
        check("R1 reset halt", int'(cpu_halt), 0);
        @(negedge clk);
        rst_n = 1;
    endtask

    // R7: a quiet line has nine refreshes at 40+4k and nothing else.
    task automatic t_quiet_line();
        int nref = 0;
        clear_all();
        for (int c = 0; c < 114; c++) begin
            step(c);
            if (owner == 3'd6) nref++;
            check("R7 quiet slot", int'(owner),
                  (c >= 40 && c <= 72 && c % 4 == 0) ? 6 : 0);
        end
        check("R7 refresh count", nref, 9);
    endtask

    // R8: a data fetch on slot 48 drops that refresh; slot 52 is unchanged.
    task automatic t_preempt();
        int nref = 0;
        clear_all();
        pf_mode = 2; pf_data_mask[48] = 1'b1;
        for (int c = 36; c < 80; c++) begin
            step(c);
            if (owner == 3'd6) nref++;
        end
        check("R8 refresh count after preempt", nref, 8);
        check_cycle("R8 preempted slot", 48, 4);
        check_cycle("R8 next slot kept", 52, 6);
        check_cycle("R8 no shifted refresh", 49, 0);
    endtask

    // R2: display-list byte counts 0..3.
    task automatic t_dlist();
        clear_all();
        dlist_en = 1;
        for (int n = 0; n <= 3; n++) begin
            dlist_bytes = 2'(n);
            for (int c = 1; c <= 3; c++) check_cycle("R2 dlist", c, (c <= n) ? 1 : 0);
        end
        dlist_en = 0;
        check_cycle("R2 dlist disabled", 1, 0);
    endtask

    // R3/R4: player and missile parity and resolution.
    task automatic t_pm();
        clear_all();
        missile_en = 1; pm_single = 0; line_odd = 1;
        check_cycle("R3 missile two-line odd", 0, 0);
        line_odd = 0;
        check_cycle("R3 missile two-line even", 0, 3);
        check_cycle("R4 missile-only no player", 4, 0);
        missile_en = 0; player_en = 1; pm_single = 1; line_odd = 1;
        check_cycle("R3 player forces missile", 0, 3);
        for (int c = 4; c <= 7; c++) check_cycle("R4 player bytes", c, 2);
        check_cycle("R4 player end", 8, 0);
        pm_single = 0;
        check_cycle("R4 player two-line odd", 5, 0);
    endtask

    // R5/R6: map versus character gating with first-line flags.
    task automatic t_playfield();
        clear_all();
        pf_data_mask[20] = 1'b1; pf_code_mask[21] = 1'b1;
        pf_mode = 0; first_instr_line = 1; first_row_line = 1;
        check_cycle("R5 mode off data", 20, 0);
        check_cycle("R6 mode off code", 21, 0);
        pf_mode = 1;
        check_cycle("R5 map first line", 20, 4);
        check_cycle("R6 map no code", 21, 0);
        first_instr_line = 0;
        check_cycle("R5 map later line", 20, 0);
        pf_mode = 2; first_row_line = 0;
        check_cycle("R5 char later line data", 20, 4);
        check_cycle("R6 char later line code", 21, 0);
        first_row_line = 1;
        check_cycle("R6 char first row code", 21, 5);
    endtask

    // R9: priority order and out-of-line counts.
    task automatic t_priority();
        clear_all();
        pf_mode = 2; first_row_line = 1;
        pf_data_mask = '1; pf_code_mask[30] = 1'b1;
        missile_en = 1; dlist_en = 1; dlist_bytes = 3; player_en = 1;
        check_cycle("R9 missile over masks", 0, 3);
        check_cycle("R9 dlist over masks", 2, 1);
        check_cycle("R9 player over masks", 6, 2);
        check_cycle("R9 code over data", 30, 5);
        check_cycle("R9 data fills gap", 31, 4);
        pf_code_mask = '1;
        check_cycle("R9 past line end", 120, 0);
    endtask

    // R10: the output follows the inputs of the previous edge.
    task automatic t_latency();
        clear_all();
        step(40);
        check("R10 refresh registered", int'(owner), 6);
        @(negedge clk);
        hcount = 7'd41;
        check("R10 held before edge", int'(owner), 6);
        @(posedge clk);
        #1;
        check("R10 updated after edge", int'(owner), 0);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_quiet_line();
                t_preempt();
                t_dlist();
                t_pm();
                t_playfield();
                t_priority();
                t_latency();
            end
            begin
                repeat (20000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule